// File: doc/BRIEF.md
# Anti-Pop Audio Output Ramp Sequencer

This block sequences the analog audio path through power-up and power-down so that the speaker stays silent. It drives five things: the DAC input code, the digital volume code, a mute-release line and the enable lines of the DAC and the power amplifier. The order of these steps and the slow ramp of the code stop the speaker terminals from jumping and making an audible click.

After a start request, the block enables the DAC at code zero with the amplifier off. It raises the code one step at a time until it reaches mid-scale. It then applies the target volume under mute and switches the amplifier on. After a settling delay it releases mute and reports ready. While ready, the DAC code follows an external sample input.

After a stop request, the block switches the amplifier off. It walks the last applied code to mid-scale, counting down from above or up from below. It then drops the volume to zero, walks the code down to zero, and finally disables the DAC and mutes. The step interval and the settling delay are parameters given in clock cycles.

Top module: `antipop_seq`

## Requirements
- R1: After reset the DAC code is 0, the volume code is 0, and mute-release, DAC enable, amplifier enable, busy and ready are all 0.
- R2: On start from idle, the next cycle shows DAC enable 1, amplifier enable 0, mute-release 1, volume 0, code 0 and busy 1. The code then rises by exactly 1 per step until it equals mid-scale, 2^(CODE_W-1).
- R3: Consecutive ramp steps are exactly STEP_CYC clock cycles apart.
- R4: The step after the code reaches mid-scale sets the volume to the target and clears mute-release. The amplifier enable rises one cycle later, with the code still at mid-scale.
- R5: Mute-release rises exactly SETTLE_CYC cycles after the amplifier enable rises. In that same cycle ready goes to 1 and busy to 0, with amplifier and DAC enabled.
- R6: While ready, the DAC code equals the sample input of the previous cycle.
- R7: On stop while ready, the next cycle shows amplifier enable 0, busy 1 and the last applied code held.
- R8: During stop, the code moves toward mid-scale by 1 per step. It decrements if above, increments if below and stays put if equal. The volume keeps its target value during this phase.
- R9: The step at which the code is at mid-scale sets the volume to 0. The code then falls by 1 per step to 0.
- R10: The step at which the code is 0 clears mute-release and DAC enable together. Busy then returns to 0.
- R11: A start request during power-down is held and begins a new power-up right after the block reaches idle. A stop request during power-up is held and begins power-down right after ready is reached.
- R12: The amplifier enable is never 1 while the DAC enable is 0.
- R13: A start request while ready and a stop request while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Power-up request pulse |
| stop_i | input | 1 | Power-down request pulse |
| target_vol_i | input | VOL_W | Volume code applied before the amplifier turns on |
| sample_i | input | CODE_W | Audio code passed to the DAC while ready |
| dac_code_o | output | CODE_W | DAC input code |
| vol_o | output | VOL_W | Digital volume code |
| unmute_o | output | 1 | Mute-release (1 = speaker driven) |
| dac_en_o | output | 1 | DAC enable |
| amp_en_o | output | 1 | Power amplifier enable |
| busy_o | output | 1 | High during either sequence |
| ready_o | output | 1 | High in the playing state |

## Verification
The bench builds the block with CODE_W=8, STEP_CYC=3 and SETTLE_CYC=20. This shrinks a full ramp to about 130 steps of three cycles. As a result, every ramp, both centring directions and the equal-to-mid-scale case can be walked code by code. The short settle window lets the exact delay from amplifier enable to mute-release be counted. The held start and stop requests can each be seen taking effect one cycle after the current sequence ends.

// File: rtl/antipop_pkg.sv
package antipop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RISE,
    ST_ARM,
    ST_SETTLE,
    ST_PLAY,
    ST_CENTER,
    ST_FALL
  } seq_st_t;
endpackage

// File: rtl/ap_tick_timer.sv
module ap_tick_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic done
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign done = en && (cnt == LAST);
endmodule

// File: rtl/ap_stepper.sv
module ap_stepper #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] goal,
  output logic [W-1:0] nxt,
  output logic         at_goal
);
  always_comb begin
    at_goal = (cur == goal);
    if (cur > goal)      nxt = cur - 1'b1;
    else if (cur < goal) nxt = cur + 1'b1;
    else                 nxt = cur;
  end
endmodule

// File: rtl/antipop_seq.sv
module antipop_seq
  import antipop_pkg::*;
#(
  parameter int unsigned CODE_W     = 16,
  parameter int unsigned VOL_W      = 7,
  parameter int unsigned STEP_CYC   = 500,
  parameter int unsigned SETTLE_CYC = 10_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [VOL_W-1:0]  target_vol_i,
  input  logic [CODE_W-1:0] sample_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [VOL_W-1:0]  vol_o,
  output logic              unmute_o,
  output logic              dac_en_o,
  output logic              amp_en_o,
  output logic              busy_o,
  output logic              ready_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  seq_st_t           st;
  logic              start_pend, stop_pend;
  logic              step_en, step_tick, settle_done;
  logic [CODE_W-1:0] goal, nxt_code;
  logic              at_goal;
  logic              start_go, stop_go;

  assign step_en  = (st == ST_RISE) || (st == ST_CENTER) || (st == ST_FALL);
  assign goal     = (st == ST_FALL) ? '0 : MID;
  assign start_go = start_i || start_pend;
  assign stop_go  = stop_i || stop_pend;

  ap_tick_timer #(.LIMIT(STEP_CYC)) u_step (
    .clk(clk), .rst(rst), .en(step_en), .done(step_tick)
  );

  ap_tick_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .en(st == ST_SETTLE), .done(settle_done)
  );

  ap_stepper #(.W(CODE_W)) u_stepper (
    .cur(dac_code_o), .goal(goal), .nxt(nxt_code), .at_goal(at_goal)
  );

  // requests arriving while the opposite sequence runs are held
  always_ff @(posedge clk) begin
    if (rst) begin
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
    end else begin
      if (st == ST_IDLE)
        start_pend <= 1'b0;
      else if (start_i && (st == ST_CENTER || st == ST_FALL))
        start_pend <= 1'b1;
      if (st == ST_PLAY)
        stop_pend <= 1'b0;
      else if (stop_i && (st == ST_RISE || st == ST_ARM || st == ST_SETTLE))
        stop_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      dac_code_o <= '0;
      vol_o      <= '0;
      unmute_o   <= 1'b0;
      dac_en_o   <= 1'b0;
      amp_en_o   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start_go) begin
          st         <= ST_RISE;
          dac_code_o <= '0;
          vol_o      <= '0;
          dac_en_o   <= 1'b1;
          amp_en_o   <= 1'b0;
          unmute_o   <= 1'b1;
        end
        ST_RISE: if (step_tick) begin
          if (at_goal) begin
            vol_o    <= target_vol_i;
            unmute_o <= 1'b0;
            st       <= ST_ARM;
          end else begin
            dac_code_o <= nxt_code;
          end
        end
        ST_ARM: begin
          amp_en_o <= 1'b1;
          st       <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_done) begin
          unmute_o <= 1'b1;
          st       <= ST_PLAY;
        end
        ST_PLAY: begin
          if (stop_go) begin
            amp_en_o <= 1'b0;
            st       <= ST_CENTER;
          end else begin
            dac_code_o <= sample_i;
          end
        end
        ST_CENTER: if (step_tick) begin
          if (at_goal) begin
            vol_o <= '0;
            st    <= ST_FALL;
          end else begin
            dac_code_o <= nxt_code;
          end
        end
        ST_FALL: if (step_tick) begin
          if (at_goal) begin
            unmute_o <= 1'b0;
            dac_en_o <= 1'b0;
            st       <= ST_IDLE;
          end else begin
            dac_code_o <= nxt_code;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st != ST_IDLE) && (st != ST_PLAY);
  assign ready_o = (st == ST_PLAY);
endmodule

// File: rtl/antipop_seq_chk.sv
module antipop_seq_chk #(
  parameter int unsigned CODE_W     = 16,
  parameter int unsigned SETTLE_CYC = 10_000_000
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              unmute_o,
  input logic              dac_en_o,
  input logic              amp_en_o,
  input logic              busy_o,
  input logic              ready_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  int unsigned settle_cnt;

  always_ff @(posedge clk) begin
    if (rst || !amp_en_o)                          settle_cnt <= 0;
    else if (!unmute_o && settle_cnt < SETTLE_CYC + 2) settle_cnt <= settle_cnt + 1;
  end

  // R12
  amp_needs_dac_chk: assert property (@(posedge clk) disable iff (rst)
    amp_en_o |-> dac_en_o);

  // R4
  amp_on_at_mid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(amp_en_o) |-> (dac_code_o == MID) && !unmute_o);

  // R5
  settle_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(unmute_o) && amp_en_o) |-> settle_cnt == SETTLE_CYC);

  // R2
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |->
      (dac_code_o == $past(dac_code_o)) ||
      (dac_code_o == $past(dac_code_o) + 1'b1) ||
      (dac_code_o == $past(dac_code_o) - 1'b1));

  // R10
  off_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_en_o) |-> (dac_code_o == '0) && !unmute_o && !amp_en_o);

  // R5
  ready_full_on_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> unmute_o && amp_en_o && dac_en_o && !busy_o);
endmodule

bind antipop_seq antipop_seq_chk #(
  .CODE_W(CODE_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .dac_code_o(dac_code_o), .unmute_o(unmute_o),
  .dac_en_o(dac_en_o), .amp_en_o(amp_en_o), .busy_o(busy_o), .ready_o(ready_o)
);

// File: tb/antipop_seq_test.sv
module antipop_seq_test;
  localparam int CW = 8;
  localparam int VW = 7;
  localparam int S  = 3;
  localparam int T  = 20;
  localparam int MID = 1 << (CW - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, stop_i = 1'b0;
  logic [VW-1:0] target_vol_i = '0;
  logic [CW-1:0] sample_i = '0;
  logic [CW-1:0] dac_code_o;
  logic [VW-1:0] vol_o;
  logic unmute_o, dac_en_o, amp_en_o, busy_o, ready_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  antipop_seq #(.CODE_W(CW), .VOL_W(VW), .STEP_CYC(S), .SETTLE_CYC(T)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .target_vol_i(target_vol_i), .sample_i(sample_i), .dac_code_o(dac_code_o),
    .vol_o(vol_o), .unmute_o(unmute_o), .dac_en_o(dac_en_o), .amp_en_o(amp_en_o),
    .busy_o(busy_o), .ready_o(ready_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready_o && n < 5000) begin @(negedge clk); n++; end
    chk(ready_o, "R11", "ready reached", ready_o, 1);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (dac_en_o && n < 5000) begin @(negedge clk); n++; end
    chk(!dac_en_o, "R10", "idle reached", dac_en_o, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cycles(4);
    @(negedge clk) rst = 1'b0;
    chk(dac_code_o == 0 && vol_o == 0, "R1", "code/vol after reset", dac_code_o, 0);
    chk({unmute_o, dac_en_o, amp_en_o, busy_o, ready_o} == 5'b0, "R1",
        "control lines after reset", {unmute_o, dac_en_o, amp_en_o, busy_o, ready_o}, 0);
  endtask

  task automatic t_powerup(input int tgt);
    int prev, bad, n;
    target_vol_i = VW'(tgt);
    pulse_start();
    chk(dac_en_o && !amp_en_o && unmute_o && busy_o && vol_o == 0 && dac_code_o == 0,
        "R2", "initial power-up state",
        {dac_en_o, amp_en_o, unmute_o, busy_o}, 4'b1011);
    // step spacing
    n = 0;
    while (dac_code_o == 0 && n < 100) begin @(negedge clk); n++; end
    chk(dac_code_o == 1, "R2", "first step value", dac_code_o, 1);
    n = 0;
    while (dac_code_o == 1 && n < 100) begin @(negedge clk); n++; end
    chk(n == S, "R3", "cycles between steps", n, S);
    // ramp to mid
    prev = dac_code_o; bad = 0; n = 0;
    while (!amp_en_o && n < 5000) begin
      @(negedge clk); n++;
      if (dac_code_o != prev && dac_code_o != prev + 1) bad++;
      prev = dac_code_o;
    end
    chk(bad == 0, "R2", "rise steps of +1", bad, 0);
    chk(amp_en_o && dac_code_o == MID, "R4", "code at amp enable", dac_code_o, MID);
    chk(vol_o == tgt && !unmute_o, "R4", "volume applied under mute", vol_o, tgt);
    n = 0;
    do begin @(negedge clk); n++; end while (!unmute_o && n < 1000);
    chk(n == T, "R5", "amp enable to mute release", n, T);
    chk(ready_o && !busy_o, "R5", "ready after settle", {ready_o, busy_o}, 2'b10);
  endtask

  task automatic t_play();
    @(negedge clk) sample_i = 8'd77;
    @(negedge clk);
    chk(dac_code_o == 77, "R6", "pass-through 77", dac_code_o, 77);
    sample_i = 8'd201;
    @(negedge clk);
    chk(dac_code_o == 201, "R6", "pass-through 201", dac_code_o, 201);
    pulse_start();
    cycles(5);
    chk(ready_o && amp_en_o && !busy_o, "R13", "start while ready ignored",
        {ready_o, amp_en_o, busy_o}, 3'b110);
  endtask

  task automatic t_powerdown(input int x, input int tgt);
    int prev, bad, n, expv;
    @(negedge clk) sample_i = CW'(x);
    @(negedge clk);
    pulse_stop();
    chk(!amp_en_o && busy_o && dac_code_o == x, "R7", "code held at stop", dac_code_o, x);
    prev = dac_code_o; bad = 0; n = 0;
    while (dac_code_o != MID && n < 5000) begin
      @(negedge clk); n++;
      expv = (prev > MID) ? prev - 1 : prev + 1;
      if (dac_code_o != prev && dac_code_o != expv) bad++;
      if (vol_o != tgt) bad++;
      prev = dac_code_o;
    end
    chk(bad == 0, "R8", "centring steps toward mid", bad, 0);
    n = 0;
    while (vol_o != 0 && n < 100) begin
      @(negedge clk); n++;
      if (dac_code_o != MID) bad++;
    end
    chk(vol_o == 0 && dac_code_o == MID && bad == 0, "R9", "volume dropped at mid",
        dac_code_o, MID);
    prev = dac_code_o; bad = 0; n = 0;
    while (dac_en_o && n < 5000) begin
      @(negedge clk); n++;
      if (dac_code_o != prev && dac_code_o != prev - 1) bad++;
      prev = dac_code_o;
    end
    chk(bad == 0, "R9", "fall steps of -1", bad, 0);
    chk(dac_code_o == 0 && !unmute_o && !dac_en_o && !busy_o && !ready_o, "R10",
        "idle after fall", dac_code_o, 0);
  endtask

  task automatic t_start_during_down();
    t_powerup(33);
    pulse_stop();
    cycles(20);
    pulse_start();
    wait_idle();
    @(negedge clk);
    chk(dac_en_o && busy_o && unmute_o && dac_code_o == 0, "R11",
        "held start restarts power-up", {dac_en_o, busy_o}, 2'b11);
    wait_ready();
  endtask

  task automatic t_stop_during_up();
    pulse_start();
    cycles(10);
    pulse_stop();
    wait_ready();
    @(negedge clk);
    chk(!amp_en_o && busy_o && !ready_o, "R11", "held stop begins power-down",
        {amp_en_o, busy_o}, 2'b01);
    wait_idle();
  endtask

  task automatic t_stop_in_idle();
    pulse_stop();
    cycles(10);
    chk(!busy_o && !dac_en_o, "R13", "stop while idle ignored", busy_o, 0);
    t_powerup(5);
    cycles(10);
    chk(ready_o && amp_en_o, "R13", "no stale stop after idle stop", ready_o, 1);
  endtask

  initial begin
    t_reset();
    t_powerup(90);
    t_play();
    t_powerdown(200, 90);   // above mid
    t_powerup(12);
    t_powerdown(50, 12);    // below mid
    t_powerup(64);
    t_powerdown(MID, 64);   // equal to mid
    t_start_during_down();
    t_powerdown(255, 33);
    t_stop_during_up();
    t_stop_in_idle();
    t_powerdown(0, 5);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule